// File: doc/BRIEF.md
# Double-Exponential-Smoothing Value Predictor

This block forecasts the next 32-bit word of a sample stream. It keeps a level estimate and a slope estimate, offers their sum as the forecast for the sample about to arrive, and refreshes both estimates each time a sample is consumed. Words are handled as raw integers, so a stream of single-precision values can be fed bit for bit. The block computes no floating-point values and does no encoding or packing.

A compressor XORs each incoming word with the forecast. A decompressor runs an identical copy of the block on the words it has rebuilt. All arithmetic wraps modulo 2^32 and both smoothing weights are powers of two, so both sides produce the same forecasts bit for bit. Each weight is given as a shift count k, meaning a weight of 2^-k. A start pulse opens a new stream. The first sample after it seeds the level. The second sample seeds the slope and moves the level to that second sample. From the third sample on, the smoothing updates apply.

Top module: `des_predictor`

## Requirements
- R1: While `rst_n` is low, `smp_ready_o` is 0 and `pred_o` is 0. `smp_ready_o` rises within three rising clock edges after `rst_n` goes high.
- R2: When no sample has been accepted since reset or since the last start pulse, `pred_o` is 0.
- R3: After the first sample y1 of a stream is accepted, `pred_o` equals y1.
- R4: After the second sample y2 is accepted, the slope becomes y2-y1, the level becomes y2, and `pred_o` equals y2+(y2-y1).
- R5: For each later sample y, with forecast P=L+S, the new level is L'=P+((y-P)>>>a) and the new slope is S'=S+((L'-L-S)>>>b). Here `>>>` is an arithmetic shift of the two's-complement 32-bit difference, a is `alpha_sh_i` and b is `beta_sh_i`, both sampled in the cycle the sample is accepted. `pred_o` then equals L'+S'.
- R6: With both shift counts 0, the forecast after sample y_n is 2*y_n - y_(n-1).
- R7: Every sum and difference wraps modulo 2^32.
- R8: A start pulse with no accepted sample makes `pred_o` 0 on the next cycle. The next two accepted samples then seed the estimates again.
- R9: A start pulse and an accepted sample in the same cycle clear the old stream, and that sample becomes the first sample of the new stream.
- R10: A cycle with no accepted sample and no start pulse leaves `pred_o` unchanged, whatever `smp_data_i` and the shift counts hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start-of-stream pulse, clears the estimates |
| smp_valid_i | input | 1 | Sample present on `smp_data_i` |
| smp_ready_o | output | 1 | Block can accept a sample |
| smp_data_i | input | 32 | Sample word, treated as a raw integer |
| alpha_sh_i | input | 5 | Level weight as a shift count (weight 2^-k) |
| beta_sh_i | input | 5 | Slope weight as a shift count (weight 2^-k) |
| pred_o | output | 32 | Forecast for the next sample to be accepted |

## Verification
The clear and the seeding can happen in the same cycle: a start pulse can arrive together with an accepted sample. The bench creates this case on purpose, in the middle of running streams and with random data. It then expects the new sample to be echoed as the forecast. A stale forecast, or a value built from the old level, counts as a failure. The bench also checks the reverse order: a start pulse on its own, followed one cycle later by a sample. In that case the forecast must drop to zero first and then show the new first sample.

// File: rtl/des_pkg.sv
`timescale 1ns/1ps
package des_pkg;
  // Progress of the current stream through its seeding steps
  typedef enum logic [1:0] {
    PH_EMPTY = 2'd0,  // no sample since start
    PH_ONE   = 2'd1,  // level seeded, slope not yet
    PH_RUN   = 2'd2   // both seeded, smoothing active
  } phase_e;
endpackage

// File: rtl/des_rst_sync.sv
`timescale 1ns/1ps
module des_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= 1'b1;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/des_update.sv
`timescale 1ns/1ps
module des_update
  import des_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  phase_e         phase_i,
  input  logic           start_i,
  input  logic [W-1:0]   level_i,
  input  logic [W-1:0]   slope_i,
  input  logic [W-1:0]   sample_i,
  input  logic [SHW-1:0] a_sh_i,
  input  logic [SHW-1:0] b_sh_i,
  output phase_e         phase_o,
  output logic [W-1:0]   level_o,
  output logic [W-1:0]   slope_o,
  output logic [W-1:0]   fcst_o
);
  logic [W-1:0]        fcst;
  logic [W-1:0]        err;
  logic signed [W-1:0] err_sh;
  logic [W-1:0]        lvl_run;
  logic [W-1:0]        trend_err;
  logic signed [W-1:0] trend_sh;
  logic [W-1:0]        slp_run;
  phase_e              eff_phase;

  always_comb begin
    fcst      = level_i + slope_i;
    fcst_o    = (phase_i == PH_EMPTY) ? '0 : fcst;
    err       = sample_i - fcst;
    err_sh    = $signed(err) >>> a_sh_i;
    lvl_run   = fcst + err_sh;
    trend_err = lvl_run - level_i - slope_i;
    trend_sh  = $signed(trend_err) >>> b_sh_i;
    slp_run   = slope_i + trend_sh;
    eff_phase = start_i ? PH_EMPTY : phase_i;
    case (eff_phase)
      PH_EMPTY: begin
        phase_o = PH_ONE;
        level_o = sample_i;
        slope_o = '0;
      end
      PH_ONE: begin
        phase_o = PH_RUN;
        level_o = sample_i;
        slope_o = sample_i - level_i;
      end
      default: begin
        phase_o = PH_RUN;
        level_o = lvl_run;
        slope_o = slp_run;
      end
    endcase
  end
endmodule

// File: rtl/des_state.sv
`timescale 1ns/1ps
module des_state
  import des_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic         clr_en,
  input  phase_e       phase_nx,
  input  logic [W-1:0] level_nx,
  input  logic [W-1:0] slope_nx,
  output phase_e       phase_q,
  output logic [W-1:0] level_q,
  output logic [W-1:0] slope_q
);
  phase_e       phase_d;
  logic [W-1:0] level_d;
  logic [W-1:0] slope_d;
  logic         st_en;

  always_comb begin
    st_en   = upd_en | clr_en;
    phase_d = phase_q;
    level_d = level_q;
    slope_d = slope_q;
    if (upd_en) begin
      phase_d = phase_nx;
      level_d = level_nx;
      slope_d = slope_nx;
    end else if (clr_en) begin
      phase_d = PH_EMPTY;
      level_d = '0;
      slope_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_EMPTY;
      level_q <= '0;
      slope_q <= '0;
    end else if (st_en) begin
      phase_q <= phase_d;
      level_q <= level_d;
      slope_q <= slope_d;
    end
  end
endmodule

// File: rtl/des_predictor.sv
`timescale 1ns/1ps
module des_predictor
  import des_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2,
  localparam int SHW        = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           smp_valid_i,
  output logic           smp_ready_o,
  input  logic [W-1:0]   smp_data_i,
  input  logic [SHW-1:0] alpha_sh_i,
  input  logic [SHW-1:0] beta_sh_i,
  output logic [W-1:0]   pred_o
);
  logic         core_rst_n;
  logic         accept;
  logic         clr_en;
  phase_e       phase_q;
  phase_e       phase_nx;
  logic [W-1:0] level_q;
  logic [W-1:0] slope_q;
  logic [W-1:0] level_nx;
  logic [W-1:0] slope_nx;

  des_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  assign smp_ready_o = core_rst_n;
  assign accept      = smp_valid_i & core_rst_n;
  assign clr_en      = start_i & core_rst_n;

  des_update #(.W(W), .SHW(SHW)) u_upd (
    .phase_i  (phase_q),
    .start_i  (start_i),
    .level_i  (level_q),
    .slope_i  (slope_q),
    .sample_i (smp_data_i),
    .a_sh_i   (alpha_sh_i),
    .b_sh_i   (beta_sh_i),
    .phase_o  (phase_nx),
    .level_o  (level_nx),
    .slope_o  (slope_nx),
    .fcst_o   (pred_o)
  );

  des_state #(.W(W)) u_st (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .upd_en   (accept),
    .clr_en   (clr_en),
    .phase_nx (phase_nx),
    .level_nx (level_nx),
    .slope_nx (slope_nx),
    .phase_q  (phase_q),
    .level_q  (level_q),
    .slope_q  (slope_q)
  );
endmodule

// File: rtl/des_predictor_chk.sv
`timescale 1ns/1ps
module des_predictor_chk #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic           smp_valid_i,
  input logic           smp_ready_o,
  input logic [W-1:0]   smp_data_i,
  input logic [SHW-1:0] alpha_sh_i,
  input logic [SHW-1:0] beta_sh_i,
  input logic [W-1:0]   pred_o
);
  logic         acc;
  logic [1:0]   seen_q;
  logic [W-1:0] last_q;

  assign acc = smp_valid_i & smp_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 2'd0;
      last_q <= '0;
    end else begin
      if (acc) last_q <= smp_data_i;
      if (start_i && smp_ready_o) seen_q <= acc ? 2'd1 : 2'd0;
      else if (acc && seen_q != 2'd2) seen_q <= seen_q + 2'd1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_ready_o |-> pred_o == '0); // R1
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q == 2'd0) |-> pred_o == '0); // R2
  AST_FIRST_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !start_i && seen_q == 2'd0) |=> pred_o == $past(smp_data_i)); // R3
  AST_SLOPE_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !start_i && seen_q == 2'd1) |=>
      pred_o == $past(smp_data_i) + $past(smp_data_i) - $past(last_q)); // R4
  AST_START_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && smp_ready_o && !smp_valid_i) |=> pred_o == '0); // R8
  AST_START_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && acc) |=> pred_o == $past(smp_data_i)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ready_o && !smp_valid_i && !start_i) |=> $stable(pred_o)); // R10
endmodule

bind des_predictor des_predictor_chk #(.W(W), .SHW(SHW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .smp_valid_i (smp_valid_i),
  .smp_ready_o (smp_ready_o),
  .smp_data_i  (smp_data_i),
  .alpha_sh_i  (alpha_sh_i),
  .beta_sh_i   (beta_sh_i),
  .pred_o      (pred_o)
);

// File: tb/test_des_predictor.sv
`timescale 1ns/1ps
module test_des_predictor;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        smp_valid_i;
  logic        smp_ready_o;
  logic [31:0] smp_data_i;
  logic [4:0]  alpha_sh_i;
  logic [4:0]  beta_sh_i;
  logic [31:0] pred_o;

  int checks   = 0;
  int failures = 0;

  // bench reference state
  int          m_cnt;
  logic [31:0] m_lvl;
  logic [31:0] m_slp;

  des_predictor i_des_predictor (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .smp_valid_i (smp_valid_i),
    .smp_ready_o (smp_ready_o),
    .smp_data_i  (smp_data_i),
    .alpha_sh_i  (alpha_sh_i),
    .beta_sh_i   (beta_sh_i),
    .pred_o      (pred_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] asr(input logic [31:0] v, input logic [4:0] k);
    logic signed [31:0] s;
    s = $signed(v) >>> k;
    return s;
  endfunction

  function automatic logic [31:0] m_pred();
    return (m_cnt == 0) ? 32'd0 : m_lvl + m_slp;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step(input logic st, input logic vl, input logic [31:0] d,
                            input logic [4:0] a, input logic [4:0] b);
    logic [31:0] p, nl;
    if (st) begin m_cnt = 0; m_lvl = 0; m_slp = 0; end
    if (vl) begin
      if (m_cnt == 0) begin
        m_lvl = d; m_slp = 0; m_cnt = 1;
      end else if (m_cnt == 1) begin
        m_slp = d - m_lvl; m_lvl = d; m_cnt = 2;
      end else begin
        p     = m_lvl + m_slp;
        nl    = p + asr(d - p, a);
        m_slp = m_slp + asr(nl - m_lvl - m_slp, b);
        m_lvl = nl;
      end
    end
  endtask

  // called at a falling edge; leaves at the next falling edge
  task automatic step(input string req, input logic st, input logic vl,
                      input logic [31:0] d, input logic [4:0] a, input logic [4:0] b);
    start_i = st; smp_valid_i = vl; smp_data_i = d;
    alpha_sh_i = a; beta_sh_i = b;
    @(posedge clk);
    model_step(st, vl, d, a, b);
    @(negedge clk);
    start_i = 1'b0; smp_valid_i = 1'b0;
    check(req, pred_o, m_pred());
  endtask

  initial begin
    #1_000_000;
    failures++; checks++;
    $display("FAIL watchdog R1 actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] y0, y1, y2, hold;
    void'($urandom(32'd1234));
    m_cnt = 0; m_lvl = 0; m_slp = 0;
    rst_n = 1'b0; start_i = 1'b0; smp_valid_i = 1'b0;
    smp_data_i = 32'h1234_5678; alpha_sh_i = 5'd1; beta_sh_i = 5'd1;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {31'd0, smp_ready_o}, 32'd0);
    check("R1 pred in reset", pred_o, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 ready after release", {31'd0, smp_ready_o}, 32'd1);
    check("R2 empty stream", pred_o, 32'd0);

    // R3, R4 seeding
    step("R3 first echo", 1'b0, 1'b1, 32'h3F80_0000, 5'd2, 5'd3);
    check("R3 direct", pred_o, 32'h3F80_0000);
    step("R4 slope seed", 1'b0, 1'b1, 32'h3F80_0100, 5'd2, 5'd3);
    check("R4 direct", pred_o, 32'h3F80_0200);
    // R5 smoothing steps
    for (int i = 0; i < 6; i++)
      step("R5 smoothing", 1'b0, 1'b1, 32'h3F80_0000 + 32'(i * 300), 5'd2, 5'd3);

    // R10 idle cycles with random data do nothing
    hold = pred_o;
    for (int i = 0; i < 4; i++)
      step("R10 idle hold", 1'b0, 1'b0, $urandom, 5'($urandom), 5'($urandom));
    check("R10 direct", pred_o, hold);

    // R8 start alone, then reseed
    step("R8 start clears", 1'b1, 1'b0, 32'hDEAD_BEEF, 5'd0, 5'd0);
    check("R8 direct zero", pred_o, 32'd0);
    step("R8 reseed first", 1'b0, 1'b1, 32'd100, 5'd0, 5'd0);
    step("R8 reseed second", 1'b0, 1'b1, 32'd110, 5'd0, 5'd0);
    check("R8 direct", pred_o, 32'd120);

    // R6 zero shifts: 2*y_n - y_(n-1)
    y0 = 32'd110;
    for (int i = 0; i < 5; i++) begin
      y1 = 32'd200 + 32'(i * i * 7);
      step("R6 zero shift", 1'b0, 1'b1, y1, 5'd0, 5'd0);
      check("R6 direct", pred_o, y1 + y1 - y0);
      y0 = y1;
    end

    // R7 wrap across 2^32
    step("R7 wrap first", 1'b1, 1'b1, 32'hFFFF_FFF0, 5'd1, 5'd1);
    step("R7 wrap second", 1'b0, 1'b1, 32'h0000_0010, 5'd1, 5'd1);
    check("R7 direct", pred_o, 32'h0000_0030);
    step("R7 wrap run", 1'b0, 1'b1, 32'h8000_0000, 5'd31, 5'd31);

    // R9 start with sample mid stream
    step("R9 start with sample", 1'b1, 1'b1, 32'hC0DE_0001, 5'd4, 5'd4);
    check("R9 direct", pred_o, 32'hC0DE_0001);

    // random streams
    for (int i = 0; i < 400; i++) begin
      logic st, vl;
      y2 = ($urandom_range(0, 3) == 0) ? $urandom : 32'h4000_0000 + 32'($urandom_range(0, 4095));
      st = ($urandom_range(0, 19) == 0);
      vl = ($urandom_range(0, 3) != 0);
      if (st && vl)      step("R9 random", st, vl, y2, 5'($urandom_range(0, 8)), 5'($urandom_range(0, 8)));
      else if (st)       step("R8 random", st, vl, y2, 5'($urandom_range(0, 8)), 5'($urandom_range(0, 8)));
      else if (!vl)      step("R10 random", st, vl, y2, 5'($urandom), 5'($urandom));
      else               step("R5 random", st, vl, y2, 5'($urandom_range(0, 8)), 5'($urandom_range(0, 8)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule